// File: doc/BRIEF.md
# Dual-Slot Receive Buffer Manager

This block decides which of two receive buffer slots takes each incoming frame. Software arms a slot by writing its state register. When the upstream datapath reports a completed frame with a one-cycle strobe and a byte length, the block puts the frame in an armed slot. Slot 0 is tried first, then slot 1. The block records the length in that slot's count register and marks the slot as full.

A level interrupt stays high while any slot holds an unserviced frame. A ready output tells the upstream logic whether a frame could be accepted now. The buffer memory, the frame bytes and the transfer engine live elsewhere.

The register file is a flat set of 32-bit words. It is addressed by word index and read combinationally. It also holds a setup word, a management word and a transmit-length word. Bit 0 of the setup word drives the PHY reset output.

Top module: `rx_slot_mgr`

## Requirements
- R1: After reset every register reads zero, and `rx_irq`, `rx_ready` and `phy_reset` are low.
- R2: The word map is as follows.
  - Index 0 is setup, index 1 is management and index 6 is transmit length. All three are full 32-bit read/write words.
  - Index 2 is the slot 0 state and index 4 is the slot 1 state. Each keeps only bits [1:0] and reads zero above them.
  - Index 3 is the slot 0 count and index 5 is the slot 1 count. Both are full 32-bit words.
  - State codes are 0 for empty, 1 for armed, 2 for full and 3 for unused.
- R3: `phy_reset` equals bit 0 of the setup word, starting the cycle after that word is written.
- R4: On a `frame_done` cycle, `frame_taken` goes high in that same cycle if slot 0 is armed, or else if slot 1 is armed. When neither slot is armed the frame is refused and `frame_taken` stays low.
- R5: On the clock edge that ends an accepted frame, the chosen slot's count becomes `frame_len` and its state becomes 2. The other slot is unchanged.
- R6: `rx_irq` is high exactly while at least one slot state equals 2.
- R7: A software write to a state register changes `rx_irq` from the next cycle.
- R8: `rx_ready` is high exactly while at least one slot state equals 1.
- R9: Word indices 7 and above read zero. Writes to them change no register.
- R10: Suppose a software write in the same cycle targets the state or count word of the slot that a frame would pick. Then the write lands, the frame is refused (`frame_taken` low) and it does not fall through to the other slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W (4) | Word index of the register access |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Combinational read data for `reg_addr` |
| frame_done | input | 1 | One-cycle strobe: a frame has completed |
| frame_len | input | LEN_W (16) | Total byte length of the completed frame |
| frame_taken | output | 1 | The frame on this cycle's strobe is accepted |
| rx_ready | output | 1 | At least one slot is armed |
| rx_irq | output | 1 | At least one slot holds a frame awaiting service |
| phy_reset | output | 1 | PHY reset, taken from setup bit 0 |

## Verification
A slot state stored wrongly shows up on the next cycle as a wrong `rx_irq` or `rx_ready` level. It also shows up at once on `frame_taken` when the next frame strobe arrives. A priority fault means the other slot's state and count words change. A collision fault means an accepted frame whose length overwrites the value software just wrote. The bench walks every pair of slot states, including the unused code. For each pair it tries no conflict, a count write to slot 0 and a state write to slot 1. After every step it reads back every word index, so a wrong register is caught within one step.

// File: rtl/rx_slot_pkg.sv
package rx_slot_pkg;

  typedef enum logic [1:0] {
    SLOT_EMPTY = 2'd0,
    SLOT_ARMED = 2'd1,
    SLOT_FULL  = 2'd2,
    SLOT_RSVD  = 2'd3
  } slot_state_e;

  localparam int unsigned NSLOT    = 2;
  localparam int unsigned A_SETUP  = 0;
  localparam int unsigned A_MGMT   = 1;
  localparam int unsigned A_STATE0 = 2;
  localparam int unsigned A_TXLEN  = 6;
  localparam int unsigned A_LAST   = 6;

  function automatic logic slot_armed(input logic [1:0] s);
    return s == SLOT_ARMED;
  endfunction

  function automatic logic slot_full(input logic [1:0] s);
    return s == SLOT_FULL;
  endfunction

  // {valid, index}: the lowest-numbered armed slot wins
  function automatic logic [1:0] pick_slot(input logic [1:0] s0, input logic [1:0] s1);
    if (slot_armed(s0)) return 2'b10;
    if (slot_armed(s1)) return 2'b11;
    return 2'b00;
  endfunction

endpackage

// File: rtl/rx_slot_pick.sv
module rx_slot_pick
  import rx_slot_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] st0,
  input  logic [1:0] st1,
  input  logic       frame_done,
  input  logic       block0,
  input  logic       block1,
  output logic       fill0,
  output logic       fill1,
  output logic       taken,
  output logic       ready
);

  logic [1:0] choice;

  always_comb begin
    choice = pick_slot(st0, st1);
    fill0  = frame_done && choice[1] && !choice[0] && !block0;
    fill1  = frame_done && choice[1] &&  choice[0] && !block1;
    taken  = fill0 || fill1;
    ready  = slot_armed(st0) || slot_armed(st1);
  end

  a_r4_one_fill: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fill0, fill1}));
  a_r4_slot1_only_if_slot0_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    fill1 |-> !slot_armed(st0));
  a_r10_blocked_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && slot_armed(st0) && block0) |-> !taken);

endmodule

// File: rtl/rx_slot_cell.sv
module rx_slot_cell
  import rx_slot_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              state_we,
  input  logic              count_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              fill,
  input  logic [LEN_W-1:0]  fill_len,
  output logic [1:0]        state,
  output logic [DATA_W-1:0] count
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SLOT_EMPTY;
      count <= '0;
    end else begin
      if (state_we)  state <= wdata[1:0];
      else if (fill) state <= SLOT_FULL;
      if (count_we)  count <= wdata;
      else if (fill) count <= DATA_W'(fill_len);
    end
  end

  a_r5_fill_marks_full: assert property (@(posedge clk) disable iff (!rst_n)
    (fill && !state_we) |=> slot_full(state));
  a_r5_fill_length: assert property (@(posedge clk) disable iff (!rst_n)
    (fill && !count_we) |=> count == DATA_W'($past(fill_len)));
  a_r2_sw_state: assert property (@(posedge clk) disable iff (!rst_n)
    state_we |=> state == $past(wdata[1:0]));

endmodule

// File: rtl/rx_slot_mgr.sv
module rx_slot_mgr
  import rx_slot_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              frame_done,
  input  logic [LEN_W-1:0]  frame_len,
  output logic              frame_taken,
  output logic              rx_ready,
  output logic              rx_irq,
  output logic              phy_reset
);

  localparam logic [ADDR_W-1:0] AD_SETUP = ADDR_W'(A_SETUP);
  localparam logic [ADDR_W-1:0] AD_MGMT  = ADDR_W'(A_MGMT);
  localparam logic [ADDR_W-1:0] AD_TXLEN = ADDR_W'(A_TXLEN);

  logic [1:0]        st    [NSLOT];
  logic [DATA_W-1:0] cnt   [NSLOT];
  logic              fill  [NSLOT];
  logic              block [NSLOT];
  logic [DATA_W-1:0] setup_q, mgmt_q, txlen_q;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    localparam logic [ADDR_W-1:0] AD_ST  = ADDR_W'(A_STATE0 + 2 * i);
    localparam logic [ADDR_W-1:0] AD_CNT = ADDR_W'(A_STATE0 + 2 * i + 1);
    logic st_we, cnt_we;
    assign st_we    = reg_we && (reg_addr == AD_ST);
    assign cnt_we   = reg_we && (reg_addr == AD_CNT);
    assign block[i] = st_we || cnt_we;

    rx_slot_cell #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .state_we (st_we),
      .count_we (cnt_we),
      .wdata    (reg_wdata),
      .fill     (fill[i]),
      .fill_len (frame_len),
      .state    (st[i]),
      .count    (cnt[i])
    );
  end

  rx_slot_pick u_pick (
    .clk        (clk),
    .rst_n      (rst_n),
    .st0        (st[0]),
    .st1        (st[1]),
    .frame_done (frame_done),
    .block0     (block[0]),
    .block1     (block[1]),
    .fill0      (fill[0]),
    .fill1      (fill[1]),
    .taken      (frame_taken),
    .ready      (rx_ready)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      setup_q <= '0;
      mgmt_q  <= '0;
      txlen_q <= '0;
    end else if (reg_we) begin
      if (reg_addr == AD_SETUP) setup_q <= reg_wdata;
      if (reg_addr == AD_MGMT)  mgmt_q  <= reg_wdata;
      if (reg_addr == AD_TXLEN) txlen_q <= reg_wdata;
    end
  end

  assign rx_irq    = slot_full(st[0]) || slot_full(st[1]);
  assign phy_reset = setup_q[0];

  always_comb begin
    case (reg_addr)
      AD_SETUP:                    reg_rdata = setup_q;
      AD_MGMT:                     reg_rdata = mgmt_q;
      ADDR_W'(A_STATE0):           reg_rdata = DATA_W'(st[0]);
      ADDR_W'(A_STATE0 + 1):       reg_rdata = cnt[0];
      ADDR_W'(A_STATE0 + 2):       reg_rdata = DATA_W'(st[1]);
      ADDR_W'(A_STATE0 + 3):       reg_rdata = cnt[1];
      AD_TXLEN:                    reg_rdata = txlen_q;
      default:                     reg_rdata = '0;
    endcase
  end

  a_r7_irq_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_irq) |-> ($past(frame_taken) || $past(reg_we)));
  a_r8_taken_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    frame_taken |-> rx_ready);
  a_r8_ready_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_ready) |-> ($past(frame_taken) || $past(reg_we)));
  a_r9_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr > ADDR_W'(A_LAST)) |-> (reg_rdata == '0));
  a_r3_phy_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == AD_SETUP) |=> (phy_reset == $past(reg_wdata[0])));

endmodule

// File: tb/rx_slot_mgr_tb_top.sv
module rx_slot_mgr_tb_top;

  localparam int DW = 32;
  localparam int AW = 4;
  localparam int LW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic          reg_we = 1'b0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          frame_done = 1'b0;
  logic [LW-1:0] frame_len = '0;
  logic          frame_taken, rx_ready, rx_irq, phy_reset;

  int checks = 0;
  int errors = 0;

  logic [1:0]  m_st  [2];
  logic [31:0] m_cnt [2];
  logic [31:0] m_setup, m_mgmt, m_tx;

  always #5 clk = ~clk;

  rx_slot_mgr #(.DATA_W(DW), .ADDR_W(AW), .LEN_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_done(frame_done),
    .frame_len(frame_len), .frame_taken(frame_taken), .rx_ready(rx_ready),
    .rx_irq(rx_irq), .phy_reset(phy_reset)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input int a);
    case (a)
      0: return m_setup;
      1: return m_mgmt;
      2: return {30'd0, m_st[0]};
      3: return m_cnt[0];
      4: return {30'd0, m_st[1]};
      5: return m_cnt[1];
      6: return m_tx;
      default: return 32'd0;
    endcase
  endfunction

  task automatic check_outs(input string tag);
    logic e_irq, e_rdy;
    e_irq = (m_st[0] == 2'd2) || (m_st[1] == 2'd2);
    e_rdy = (m_st[0] == 2'd1) || (m_st[1] == 2'd1);
    chk(rx_irq == e_irq, {tag, " R6 R7 irq"}, 32'(rx_irq), 32'(e_irq));
    chk(rx_ready == e_rdy, {tag, " R8 ready"}, 32'(rx_ready), 32'(e_rdy));
    chk(phy_reset == m_setup[0], {tag, " R3 phy_reset"}, 32'(phy_reset), 32'(m_setup[0]));
  endtask

  task automatic check_regs(input string tag);
    for (int a = 0; a < 16; a++) begin
      reg_addr = AW'(a);
      #1;
      chk(reg_rdata == m_read(a), $sformatf("%s R2 R9 word %0d", tag, a), reg_rdata, m_read(a));
    end
  endtask

  // one cycle: optional write and optional frame, starting just after a negedge
  task automatic step(input bit we, input int a, input logic [31:0] d,
                      input bit fd, input logic [15:0] len, input string tag);
    bit e0, e1, c0, c1, etake;
    reg_we = we; reg_addr = AW'(a); reg_wdata = d;
    frame_done = fd; frame_len = len;
    e0 = fd && (m_st[0] == 2'd1);
    e1 = fd && !e0 && (m_st[1] == 2'd1);
    c0 = we && (a == 2 || a == 3);
    c1 = we && (a == 4 || a == 5);
    etake = (e0 && !c0) || (e1 && !c1);
    #1;
    chk(frame_taken == etake, {tag, " R4 R10 taken"}, 32'(frame_taken), 32'(etake));
    @(posedge clk);
    if (e0 && !c0) begin m_st[0] = 2'd2; m_cnt[0] = 32'(len); end
    if (e1 && !c1) begin m_st[1] = 2'd2; m_cnt[1] = 32'(len); end
    if (we) begin
      case (a)
        0: m_setup = d;
        1: m_mgmt = d;
        2: m_st[0] = d[1:0];
        3: m_cnt[0] = d;
        4: m_st[1] = d[1:0];
        5: m_cnt[1] = d;
        6: m_tx = d;
        default: ;
      endcase
    end
    @(negedge clk);
    reg_we = 1'b0; frame_done = 1'b0;
    #1;
    check_outs(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_st[0] = 0; m_st[1] = 0; m_cnt[0] = 0; m_cnt[1] = 0;
    m_setup = 0; m_mgmt = 0; m_tx = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check_outs("R1 reset");
    check_regs("R1 reset");

    // R2 R3 plain words
    step(1, 0, 32'hA5A5_0001, 0, 0, "R3 setup");
    step(1, 1, 32'h1234_5678, 0, 0, "R2 mgmt");
    step(1, 6, 32'h0000_05FA, 0, 0, "R2 txlen");
    step(1, 0, 32'hFFFF_FFFE, 0, 0, "R3 setup clr");
    check_regs("R2 plain");

    // R9 writes to holes change nothing
    for (int a = 7; a < 16; a++) step(1, a, 32'hDEAD_BEEF, 0, 0, "R9 hole write");
    check_regs("R9 after holes");

    // R4 R5 R10 sweep over every state pair and conflict kind
    for (int s0 = 0; s0 < 4; s0++) begin
      for (int s1 = 0; s1 < 4; s1++) begin
        for (int k = 0; k < 3; k++) begin
          logic [15:0] len;
          len = 16'(64 + s0 * 16 + s1 * 4 + k);
          step(1, 2, 32'(s0) | 32'hFFFF_FFF0, 0, 0, "R2 arm0");
          step(1, 4, 32'(s1), 0, 0, "R2 arm1");
          case (k)
            0: step(0, 0, 0, 1, len, "R4 R5 frame");
            1: step(1, 3, 32'h0000_0BAD, 1, len, "R10 count0 clash");
            default: step(1, 4, 32'd1, 1, len, "R10 state1 clash");
          endcase
          check_regs("R5 sweep");
        end
      end
    end

    // R7 software clears full slots, irq drops next cycle
    step(1, 2, 32'd2, 0, 0, "R7 set full0");
    step(1, 4, 32'd0, 0, 0, "R7 clr1");
    step(1, 2, 32'd0, 0, 0, "R7 clr0");
    // R4 back-to-back frames fill slot 0 then slot 1, then refuse
    step(1, 2, 32'd1, 0, 0, "R8 arm0");
    step(1, 4, 32'd1, 0, 0, "R8 arm1");
    step(0, 0, 0, 1, 16'd100, "R4 first");
    step(0, 0, 0, 1, 16'd200, "R4 second");
    step(0, 0, 0, 1, 16'd300, "R4 refused");
    check_regs("R5 final");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule